// File: doc/BRIEF.md
# Four-Lane Staggered Stress Pattern Generator

This block produces an endless stream of test packets on a four-lane parallel interface that carries one byte per lane per column, plus one control flag per lane. Each packet body is made of fixed column values, and each value is held for a set number of columns. The pattern gives every lane a low-transition-density stretch and a high-transition-density stretch. Lanes 3 and 1 run these stretches in the opposite order to lanes 2 and 0. As a result, the edges on the four lanes never switch together the way they would if one core were copied onto all lanes. Disparity-flipping bytes sit in chosen lanes, so neighbouring lanes tend to run with opposite disparity.

A mode input picks the variant for each packet. The long variant sends the core twice, and the short variant sends it once. Each variant has its own disparity-control column at the start of the body and its own fixed check column at the end. After each packet comes a three-column gap made of terminate, align and skip control columns. The gap has an odd number of rows, so running disparity alternates from one packet to the next. A ready input gates every column step. A packet strobe and a column index come out so that a downstream checker can line up each column with the table.

Top module: `jpg_pattern_gen`

## Requirements
- R1: Lane 3 is carried on `tx_data[31:24]` and lane 0 on `tx_data[7:0]`. Lane n's control flag is `tx_ctrl[n]`.
- R2: A packet opens with a start column and then a preamble column.
  - Start column: lane 0 = FB, lanes 3..1 = 55, `tx_ctrl` = 0001, `pkt_start` high, `col_idx` 0.
  - Preamble column: lanes 3..0 = D5,55,55,55.
- R3: Column 2 of the packet is the disparity column. It is 55,00,07,07 (lanes 3..0) in the long variant and 55,55,07,07 in the short variant.
- R4: The core is 188 columns long. Lanes 3..0 and run lengths are:
  - 7E,B5,7E,B5 for 40 columns.
  - Eight single columns with lanes 3 and 1 at 7E, while lanes 2 and 0 alternate EB and F4, starting with EB.
  - 7E on all lanes for 84 columns.
  - Seven single columns with lanes 2 and 0 at 7E, while lanes 3 and 1 alternate F4 and EB, starting with F4.
  - AB,7E,AB,7E.
  - B5,7E,B5,7E for 40 columns.
  - Seven single columns alternating EB,F4,EB,F4 and F4,EB,F4,EB, starting with the former.
  - F4,AB,F4,AB.
- R5: In the long variant the core is sent twice back to back. It is followed by the check column DD,09,AE,5B, so the check column sits at index 379.
- R6: In the short variant the core is sent once. It is followed by the check column CC,08,09,CA at index 191.
- R7: After the check column come three columns, each with `tx_ctrl` = 1111:
  - BC,BC,BC,FD (terminate in lane 0).
  - 7C on all lanes.
  - 1C on all lanes.
  The next start column follows them.
- R8: While `ready` is low at a clock edge, `tx_data`, `tx_ctrl`, `pkt_start` and `col_idx` do not change at that edge.
- R9: `long_mode` is sampled only at the edge that moves the stream into a start column. Its value at any other time has no effect on the packet in progress.
- R10: A synchronous reset makes the output 07 on all lanes with `tx_ctrl` = 1111 and `col_idx` 0. The ready steps that follow give the 7C column, then the 1C column, then a start column.
- R11: Every column from the preamble through the check column has `tx_ctrl` = 0000. The start column is the only one with a single flag set.
- R12: `col_idx` is 0 on the start column and rises by one with every ready step up to the last gap column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ready | input | 1 | Advance to the next column at this edge |
| long_mode | input | 1 | 1 selects the two-core variant, 0 the one-core variant |
| tx_data | output | 32 | Column bytes, lane 3 most significant |
| tx_ctrl | output | 4 | Per-lane control flags |
| pkt_start | output | 1 | High while the start column is presented |
| col_idx | output | IDX_W (9 by default) | Column index within the packet and its gap |

## Verification
Two events can fall on the same edge:
- `ready` low at the edge where a repeat run ends and the table entry would change.
- A change of `long_mode` near the edge where a gap closes and the next packet starts.

The bench drives `ready` with a pseudo-random sequence, so stalls land on run boundaries, inside long runs and on the final skip column. It also drives `long_mode` to the opposite of the wanted variant everywhere except on the last gap column. A wrong sampling point then shows up as the wrong disparity column, the wrong check column or a wrong packet length. Each column is compared with a model that counts the packet offset arithmetically, and each stalled edge is also compared with the previous sample.

// File: rtl/jpg_pkg.sv
package jpg_pkg;

   localparam int LANES        = 4;
   localparam int BYTE_W       = 8;
   localparam int CORE_ENTRIES = 27;
   localparam int ENTRY_W      = $clog2(CORE_ENTRIES);
   localparam int LAST_ENTRY   = CORE_ENTRIES - 1;
   localparam int SINGLE_COLS  = 24;

   typedef logic [LANES-1:0][BYTE_W-1:0] column_t;
   typedef logic [LANES-1:0]             flags_t;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_START,
      PH_PREAMBLE,
      PH_DISP,
      PH_CORE,
      PH_CHECK,
      PH_TERM,
      PH_ALIGN,
      PH_SKIP
   } phase_t;

   localparam logic [BYTE_W-1:0] B_IDLE  = 8'h07;
   localparam logic [BYTE_W-1:0] B_START = 8'hFB;
   localparam logic [BYTE_W-1:0] B_TERM  = 8'hFD;
   localparam logic [BYTE_W-1:0] B_KCHR  = 8'hBC;
   localparam logic [BYTE_W-1:0] B_ALIGN = 8'h7C;
   localparam logic [BYTE_W-1:0] B_SKIP  = 8'h1C;
   localparam logic [BYTE_W-1:0] B_PRE   = 8'h55;
   localparam logic [BYTE_W-1:0] B_SFD   = 8'hD5;

   localparam column_t DISP_LONG  = {8'h55, 8'h00, 8'h07, 8'h07};
   localparam column_t DISP_SHORT = {8'h55, 8'h55, 8'h07, 8'h07};
   localparam column_t CHK_LONG   = {8'hDD, 8'h09, 8'hAE, 8'h5B};
   localparam column_t CHK_SHORT  = {8'hCC, 8'h08, 8'h09, 8'hCA};

   // Column value of one core table entry (lanes 3..0).
   function automatic column_t core_column(input logic [ENTRY_W-1:0] entry);
      int unsigned e;
      column_t     c;
      e = 32'(entry);
      if (e == 0)
         c = {8'h7E, 8'hB5, 8'h7E, 8'hB5};
      else if (e <= 8)
         c = e[0] ? {8'h7E, 8'hEB, 8'h7E, 8'hEB} : {8'h7E, 8'hF4, 8'h7E, 8'hF4};
      else if (e == 9)
         c = {8'h7E, 8'h7E, 8'h7E, 8'h7E};
      else if (e <= 16)
         c = e[0] ? {8'hEB, 8'h7E, 8'hEB, 8'h7E} : {8'hF4, 8'h7E, 8'hF4, 8'h7E};
      else if (e == 17)
         c = {8'hAB, 8'h7E, 8'hAB, 8'h7E};
      else if (e == 18)
         c = {8'hB5, 8'h7E, 8'hB5, 8'h7E};
      else if (e <= 25)
         c = e[0] ? {8'hEB, 8'hF4, 8'hEB, 8'hF4} : {8'hF4, 8'hEB, 8'hF4, 8'hEB};
      else
         c = {8'hF4, 8'hAB, 8'hF4, 8'hAB};
      return c;
   endfunction

   // Number of columns for which one core entry is held.
   function automatic int unsigned core_reps(input logic [ENTRY_W-1:0] entry,
                                             input int unsigned edge_run,
                                             input int unsigned mid_run);
      int unsigned e;
      e = 32'(entry);
      if (e == 0 || e == 18)
         return edge_run;
      else if (e == 9)
         return mid_run;
      else
         return 1;
   endfunction

endpackage

// File: rtl/jpg_rep_counter.sv
module jpg_rep_counter #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (dec && cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/jpg_sequencer.sv
module jpg_sequencer
   import jpg_pkg::*;
#(
   parameter int REP_EDGE    = 40,
   parameter int REP_MID     = 84,
   parameter int LONG_PASSES = 2,
   parameter int CNT_W       = 7,
   parameter int IDX_W       = 9
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               ready,
   input  logic               long_mode,
   input  logic               run_done,
   output logic               cnt_load,
   output logic [CNT_W-1:0]   cnt_val,
   output logic               cnt_dec,
   output phase_t             phase,
   output logic [ENTRY_W-1:0] entry,
   output logic               long_sel,
   output logic [IDX_W-1:0]   col_idx
);

   localparam int PASS_W = (LONG_PASSES > 1) ? $clog2(LONG_PASSES) : 1;
   localparam logic [PASS_W-1:0]  PASS_LAST = PASS_W'(LONG_PASSES - 1);
   localparam logic [ENTRY_W-1:0] ENTRY_END = ENTRY_W'(LAST_ENTRY);

   phase_t             phase_q, phase_d;
   logic [ENTRY_W-1:0] entry_q, entry_d;
   logic [PASS_W-1:0]  pass_q, pass_d;
   logic               long_q, long_d;
   logic [IDX_W-1:0]   idx_q, idx_d;

   always_comb begin
      phase_d  = phase_q;
      entry_d  = entry_q;
      pass_d   = pass_q;
      long_d   = long_q;
      idx_d    = idx_q;
      cnt_load = 1'b0;
      cnt_dec  = 1'b0;
      if (ready) begin
         idx_d = idx_q + 1'b1;
         unique case (phase_q)
            PH_IDLE:     phase_d = PH_ALIGN;
            PH_START:    phase_d = PH_PREAMBLE;
            PH_PREAMBLE: phase_d = PH_DISP;
            PH_DISP: begin
               phase_d  = PH_CORE;
               entry_d  = '0;
               pass_d   = '0;
               cnt_load = 1'b1;
            end
            PH_CORE: begin
               if (!run_done) begin
                  cnt_dec = 1'b1;
               end else if (entry_q == ENTRY_END) begin
                  if (long_q && pass_q != PASS_LAST) begin
                     entry_d  = '0;
                     pass_d   = pass_q + 1'b1;
                     cnt_load = 1'b1;
                  end else begin
                     phase_d = PH_CHECK;
                  end
               end else begin
                  entry_d  = entry_q + 1'b1;
                  cnt_load = 1'b1;
               end
            end
            PH_CHECK:    phase_d = PH_TERM;
            PH_TERM:     phase_d = PH_ALIGN;
            PH_ALIGN:    phase_d = PH_SKIP;
            PH_SKIP: begin
               phase_d = PH_START;
               long_d  = long_mode;
               idx_d   = '0;
            end
            default:     phase_d = PH_IDLE;
         endcase
      end
   end

   assign cnt_val = CNT_W'(core_reps(entry_d, REP_EDGE, REP_MID) - 1);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_IDLE;
         entry_q <= '0;
         pass_q  <= '0;
         long_q  <= 1'b0;
         idx_q   <= '0;
      end else begin
         phase_q <= phase_d;
         entry_q <= entry_d;
         pass_q  <= pass_d;
         long_q  <= long_d;
         idx_q   <= idx_d;
      end
   end

   assign phase    = phase_q;
   assign entry    = entry_q;
   assign long_sel = long_q;
   assign col_idx  = idx_q;

endmodule

// File: rtl/jpg_column_mux.sv
module jpg_column_mux
   import jpg_pkg::*;
(
   input  phase_t             phase,
   input  logic [ENTRY_W-1:0] entry,
   input  logic               long_sel,
   output column_t            col,
   output flags_t             flags
);

   always_comb begin
      col   = '0;
      flags = '0;
      unique case (phase)
         PH_IDLE: begin
            col   = {LANES{B_IDLE}};
            flags = '1;
         end
         PH_START: begin
            col   = {B_PRE, B_PRE, B_PRE, B_START};
            flags = 4'b0001;
         end
         PH_PREAMBLE: col = {B_SFD, B_PRE, B_PRE, B_PRE};
         PH_DISP:     col = long_sel ? DISP_LONG : DISP_SHORT;
         PH_CORE:     col = core_column(entry);
         PH_CHECK:    col = long_sel ? CHK_LONG : CHK_SHORT;
         PH_TERM: begin
            col   = {B_KCHR, B_KCHR, B_KCHR, B_TERM};
            flags = '1;
         end
         PH_ALIGN: begin
            col   = {LANES{B_ALIGN}};
            flags = '1;
         end
         PH_SKIP: begin
            col   = {LANES{B_SKIP}};
            flags = '1;
         end
         default: begin
            col   = {LANES{B_IDLE}};
            flags = '1;
         end
      endcase
   end

endmodule

// File: rtl/jpg_pattern_gen.sv
module jpg_pattern_gen
   import jpg_pkg::*;
#(
   parameter  int REP_EDGE    = 40,
   parameter  int REP_MID     = 84,
   parameter  int LONG_PASSES = 2,
   localparam int CORE_COLS   = 2 * REP_EDGE + REP_MID + SINGLE_COLS,
   localparam int PKT_MAX     = 3 + LONG_PASSES * CORE_COLS + 4,
   localparam int IDX_W       = $clog2(PKT_MAX)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    ready,
   input  logic                    long_mode,
   output logic [LANES*BYTE_W-1:0] tx_data,
   output logic [LANES-1:0]        tx_ctrl,
   output logic                    pkt_start,
   output logic [IDX_W-1:0]        col_idx
);

   localparam int REP_MAX = (REP_EDGE > REP_MID) ? REP_EDGE : REP_MID;
   localparam int CNT_W   = $clog2(REP_MAX + 1);

   generate
      if (REP_EDGE < 1 || REP_MID < 1) begin : g_bad_runs
         $error("jpg_pattern_gen: run lengths must be at least one column");
      end
      if (LONG_PASSES < 2) begin : g_bad_passes
         $error("jpg_pattern_gen: long variant needs at least two core passes");
      end
   endgenerate

   logic               cnt_load, cnt_dec, run_done, long_sel;
   logic [CNT_W-1:0]   cnt_val;
   phase_t             phase;
   logic [ENTRY_W-1:0] entry;
   column_t            col;
   flags_t             flags;

   jpg_sequencer #(
      .REP_EDGE    (REP_EDGE),
      .REP_MID     (REP_MID),
      .LONG_PASSES (LONG_PASSES),
      .CNT_W       (CNT_W),
      .IDX_W       (IDX_W)
   ) u_seq (
      .clk       (clk),
      .rst       (rst),
      .ready     (ready),
      .long_mode (long_mode),
      .run_done  (run_done),
      .cnt_load  (cnt_load),
      .cnt_val   (cnt_val),
      .cnt_dec   (cnt_dec),
      .phase     (phase),
      .entry     (entry),
      .long_sel  (long_sel),
      .col_idx   (col_idx)
   );

   jpg_rep_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .load     (cnt_load),
      .load_val (cnt_val),
      .dec      (cnt_dec),
      .zero     (run_done)
   );

   jpg_column_mux u_mux (
      .phase    (phase),
      .entry    (entry),
      .long_sel (long_sel),
      .col      (col),
      .flags    (flags)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign tx_data[g*BYTE_W +: BYTE_W] = col[g];
      assign tx_ctrl[g]                  = flags[g];
   end

   assign pkt_start = (phase == PH_START);

endmodule

// File: rtl/jpg_checker.sv
module jpg_checker #(
   parameter int IDX_W = 9
) (
   input logic             clk,
   input logic             rst,
   input logic             ready,
   input logic [31:0]      tx_data,
   input logic [3:0]       tx_ctrl,
   input logic             pkt_start,
   input logic [IDX_W-1:0] col_idx
);

   // R10: reset leaves idle on every lane
   a_r10_reset_idle: assert property (@(posedge clk)
      rst |=> (tx_ctrl == 4'hF && tx_data == 32'h07070707 && col_idx == '0));

   // R8: a stalled edge changes nothing
   a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
      !ready |=> ($stable(tx_data) && $stable(tx_ctrl) && $stable(pkt_start) && $stable(col_idx)));

   // R2: start column contents
   a_r2_start_column: assert property (@(posedge clk) disable iff (rst)
      pkt_start |-> (tx_ctrl == 4'b0001 && tx_data[7:0] == 8'hFB && col_idx == '0));

   // R11: the single lane-0 flag appears only on the start column
   a_r11_s_flag_only: assert property (@(posedge clk) disable iff (rst)
      (tx_ctrl == 4'b0001) |-> pkt_start);

   // R12: data columns step the index by one
   a_r12_index_step: assert property (@(posedge clk) disable iff (rst)
      (ready && tx_ctrl == 4'h0) |=> (col_idx == $past(col_idx) + 1'b1));

   // R7: the skip column is followed by a packet start
   a_r7_skip_then_start: assert property (@(posedge clk) disable iff (rst)
      (ready && tx_ctrl == 4'hF && tx_data == 32'h1C1C1C1C) |=> pkt_start);

endmodule

bind jpg_pattern_gen jpg_checker #(.IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .ready     (ready),
   .tx_data   (tx_data),
   .tx_ctrl   (tx_ctrl),
   .pkt_start (pkt_start),
   .col_idx   (col_idx)
);

// File: tb/jpg_pattern_gen_tb.sv
module jpg_pattern_gen_tb;

   localparam int CLK_PERIOD = 10;
   localparam int EDGE_RUN   = 40;
   localparam int MID_RUN    = 84;
   localparam int CORE_LEN   = 2 * EDGE_RUN + MID_RUN + 24;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ready = 1'b1;
   logic long_mode = 1'b1;
   logic [31:0] tx_data;
   logic [3:0]  tx_ctrl;
   logic        pkt_start;
   logic [8:0]  col_idx;

   always #(CLK_PERIOD/2) clk = ~clk;

   jpg_pattern_gen u_dut (
      .clk       (clk),
      .rst       (rst),
      .ready     (ready),
      .long_mode (long_mode),
      .tx_data   (tx_data),
      .tx_ctrl   (tx_ctrl),
      .pkt_start (pkt_start),
      .col_idx   (col_idx)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   // model state: -1 idle after reset, -2 align, -3 skip, >=0 packet offset
   int st;
   bit lng;
   int exp_idx;
   int pkt_cnt;
   bit prev_rdy;
   logic [31:0] prev_data;
   logic [8:0]  prev_idx;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic int pkt_len(input bit l);
      return 7 + (l ? 2 : 1) * CORE_LEN;
   endfunction

   function automatic logic [31:0] core_at(input int o);
      int i;
      if (o < EDGE_RUN) return 32'h7EB57EB5;
      if (o < EDGE_RUN + 8) begin
         i = o - EDGE_RUN;
         return (i % 2 == 0) ? 32'h7EEB7EEB : 32'h7EF47EF4;
      end
      if (o < EDGE_RUN + 8 + MID_RUN) return 32'h7E7E7E7E;
      if (o < EDGE_RUN + 15 + MID_RUN) begin
         i = o - (EDGE_RUN + 8 + MID_RUN);
         return (i % 2 == 0) ? 32'hF47EF47E : 32'hEB7EEB7E;
      end
      if (o == EDGE_RUN + 15 + MID_RUN) return 32'hAB7EAB7E;
      if (o < 2 * EDGE_RUN + 16 + MID_RUN) return 32'hB57EB57E;
      if (o < 2 * EDGE_RUN + 23 + MID_RUN) begin
         i = o - (2 * EDGE_RUN + 16 + MID_RUN);
         return (i % 2 == 0) ? 32'hEBF4EBF4 : 32'hF4EBF4EB;
      end
      return 32'hF4ABF4AB;
   endfunction

   function automatic logic [35:0] exp_at(input int s, input bit l);
      int chk_pos;
      chk_pos = 3 + (l ? 2 : 1) * CORE_LEN;
      if (s == -1) return {4'hF, 32'h07070707};
      if (s == -2) return {4'hF, 32'h7C7C7C7C};
      if (s == -3) return {4'hF, 32'h1C1C1C1C};
      if (s == 0)  return {4'h1, 32'h555555FB};
      if (s == 1)  return {4'h0, 32'hD5555555};
      if (s == 2)  return {4'h0, l ? 32'h55000707 : 32'h55550707};
      if (s < chk_pos) return {4'h0, core_at((s - 3) % CORE_LEN)};
      if (s == chk_pos) return {4'h0, l ? 32'hDD09AE5B : 32'hCC0809CA};
      if (s == chk_pos + 1) return {4'hF, 32'hBCBCBCFD};
      if (s == chk_pos + 2) return {4'hF, 32'h7C7C7C7C};
      return {4'hF, 32'h1C1C1C1C};
   endfunction

   function automatic string req_of(input int s, input bit l);
      int chk_pos;
      chk_pos = 3 + (l ? 2 : 1) * CORE_LEN;
      if (s < 0) return "R10";
      if (s <= 1) return "R2";
      if (s == 2) return "R3";
      if (s < chk_pos) return (l && s >= 3 + CORE_LEN) ? "R5" : "R4";
      if (s == chk_pos) return l ? "R5" : "R6";
      return "R7";
   endfunction

   task automatic compare();
      logic [35:0] e;
      string r;
      e = exp_at(st, lng);
      r = req_of(st, lng);
      chk(tx_data == e[31:0], r, "tx_data", 64'(tx_data), 64'(e[31:0]));
      chk(tx_ctrl == e[35:32], (st >= 1 && st <= pkt_len(lng) - 4) ? "R11" : r,
          "tx_ctrl", 64'(tx_ctrl), 64'(e[35:32]));
      chk(col_idx == 9'(exp_idx), "R12", "col_idx", 64'(col_idx), 64'(exp_idx));
      chk(pkt_start == (st == 0), "R2", "pkt_start", 64'(pkt_start), 64'(st == 0));
      if (st == 0)
         chk(tx_data[7:0] == 8'hFB && tx_data[31:24] == 8'h55, "R1", "lane order",
             64'(tx_data), 64'h555555FB);
      if (st == 2)
         chk(tx_data[23:16] == (lng ? 8'h00 : 8'h55), "R9", "latched variant lane 2",
             64'(tx_data[23:16]), lng ? 64'h00 : 64'h55);
      if (!prev_rdy)
         chk(tx_data == prev_data && col_idx == prev_idx, "R8", "stalled column",
             64'({col_idx, tx_data}), 64'({prev_idx, prev_data}));
      prev_data = tx_data;
      prev_idx  = col_idx;
   endtask

   // drive at negedge, clock, update the model, compare at the next negedge
   task automatic step(input bit rdy, input bit lm);
      ready     = rdy;
      long_mode = lm;
      @(posedge clk);
      if (rdy) begin
         exp_idx++;
         if (st == -1) st = -2;
         else if (st == -2) st = -3;
         else if (st == -3 || st == pkt_len(lng) - 1) begin
            st = 0;
            lng = lm;
            exp_idx = 0;
            pkt_cnt++;
         end else st++;
      end
      prev_rdy = rdy;
      @(negedge clk);
      compare();
   endtask

   task automatic do_reset();
      rst = 1'b1;
      ready = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      chk(tx_data == 32'h07070707 && tx_ctrl == 4'hF, "R10", "reset column",
          64'({tx_ctrl, tx_data}), 64'h0F07070707);
      chk(col_idx == 9'd0 && pkt_start == 1'b0, "R10", "reset index",
          64'({pkt_start, col_idx}), 64'h0);
      rst = 1'b0;
      st = -1;
      exp_idx = 0;
      prev_rdy = 1'b1;
      prev_data = tx_data;
      prev_idx = col_idx;
   endtask

   initial begin : main
      logic [15:0] lfsr;
      bit [5:0] plan;
      bit rdy, nv, at_skip;
      lfsr = 16'hACE1;
      plan = 6'b011001;
      pkt_cnt = 0;
      lng = 1'b0;
      @(negedge clk);
      do_reset();
      while (pkt_cnt < 7) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         rdy = (pkt_cnt < 2) ? 1'b1 : (lfsr[1:0] != 2'b00);
         nv = plan[pkt_cnt % 6];
         at_skip = (st == -3) || (st >= 0 && st == pkt_len(lng) - 1);
         step(rdy, at_skip ? nv : ~nv);
      end
      while (st != 60) step(1'b1, 1'b0);
      do_reset();
      for (int n = 0; n < 8; n++) step(1'b1, 1'b0);
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog R12: actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule